// File: doc/BRIEF.md
# Lease-Based Self-Validating L1 Cache Controller

This block is a small direct-mapped first-level cache controller for a coherence scheme that uses time instead of invalidation messages. When a line is fetched it receives an absolute expiry stamp. The stamp is the global time at the moment of the fetch plus a programmable lease length. A line counts as usable only while that stamp has not fallen behind a shared global time input. No other agent ever invalidates the line, so once the stamp is passed the line simply stops hitting.

Stores are never held locally. Every store goes out to the second-level cache. It goes as a plain write when the line is not usable here, and as a lease-carrying write when it is. In the second case the local copy is updated too. Each write acknowledgement returns a completion time. A per-thread register keeps the largest completion time seen for that thread. A fence from a thread is held until global time reaches that register.

The core side uses a valid/ready request handshake and gets a single-cycle response pulse. Only one operation is in flight at a time: a load miss, a store awaiting its acknowledgement, or a fence that is waiting.

Top module: `lease_l1`

## Requirements
- R1: After reset the controller is idle (`coreReqReady` high, no response, no L2 request), every line is unusable, and every thread's stall time is 0.
- R2: A load whose line holds a valid bit, a matching tag and a stamp not less than `globalTime` is served without any L2 request. `coreRespValid` pulses for one cycle, two clock edges after the accepting edge.
- R3: A load to a line that is invalid, holds another tag, or has a stamp below `globalTime` issues a fetch request (`l2ReqKind` 0). Its `l2ReqTime` equals `globalTime + leaseLen`, both sampled in the cycle after acceptance. The request stays stable until `l2ReqReady`.
- R4: A fill response (`l2RespKind` 0) installs the line as valid, with the requested tag, the returned data and the stamp sent in the fetch. The returned data is also delivered on `coreRespData`.
- R5: A store to a usable line sends a lease-carrying write (`l2ReqKind` 2) whose `l2ReqTime` is that line's stamp. It also updates the local copy, so a later hitting load returns the stored data.
- R6: A store to a line that is not usable sends a plain write (`l2ReqKind` 1) with `l2ReqTime` 0 and does not allocate the line. A later load to that address misses.
- R7: A store completes only when an acknowledgement (`l2RespKind` 1) arrives. The storing thread's stall time then becomes the maximum of its old value and `l2RespGwct`.
- R8: A fence responds only once `globalTime` is at least the stall time of its own thread. Fence op codes are 2 and 3; load is 0 and store is 1.
- R9: Only one operation is outstanding. `coreReqReady` is low from the accepting edge until the response pulse has ended, and it is never high while an L2 request or a core response is presented.
- R10: The line index is address bits [IDX_W-1:0] and the tag is the remaining upper bits. Two addresses with the same index and different tags evict each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| globalTime | input | TIME_W | Shared global time |
| leaseLen | input | TIME_W | Lease length added to global time on a fetch |
| coreReqValid | input | 1 | Core request valid |
| coreReqReady | output | 1 | Controller can accept a request |
| coreReqOp | input | 2 | 0 load, 1 store, 2/3 fence |
| coreReqThread | input | THR_W | Issuing thread |
| coreReqAddr | input | ADDR_W | Word address |
| coreReqWdata | input | DATA_W | Store data |
| coreRespValid | output | 1 | One-cycle completion pulse |
| coreRespData | output | DATA_W | Load data (valid for loads) |
| l2ReqValid | output | 1 | L2 request valid |
| l2ReqReady | input | 1 | L2 accepts request |
| l2ReqKind | output | 2 | 0 fetch, 1 plain write, 2 lease-carrying write |
| l2ReqAddr | output | ADDR_W | Request address |
| l2ReqData | output | DATA_W | Write data |
| l2ReqTime | output | TIME_W | Fetch stamp, line stamp, or 0 |
| l2RespValid | input | 1 | L2 response valid |
| l2RespKind | input | 1 | 0 fill, 1 write acknowledgement |
| l2RespData | input | DATA_W | Fill data |
| l2RespGwct | input | TIME_W | Write completion time on acknowledgement |

## Verification
The bench freezes global time and loads a line, then hits it and stores to it. This confirms that a hit makes no L2 traffic and that the stored word is read back locally; a controller that skipped the local update would return stale data. It then lets time run past the stamp and loads again, catching a design that compares the stamp the wrong way or keeps hitting forever. It sends two acknowledgements to one thread, the smaller arriving second. A fence that returns early exposes a register that overwrites instead of taking the maximum, and a fence on another thread that returns at once exposes a register shared across threads. Index conflicts, stores to absent lines followed by loads, and L2 backpressure are compared clock by clock against a behavioural model.

// File: rtl/lease_l1_pkg.sv
package lease_l1_pkg;

  typedef enum logic [1:0] {
    OP_LOAD  = 2'd0,
    OP_STORE = 2'd1,
    OP_FENCE = 2'd2
  } coreOp_e;

  typedef enum logic [1:0] {
    L2_GETV   = 2'd0,
    L2_WRITE  = 2'd1,
    L2_WRITEV = 2'd2
  } l2Kind_e;

  localparam logic RESP_FILL = 1'b0;
  localparam logic RESP_ACK  = 1'b1;

  // Strobes from control to datapath
  typedef struct packed {
    logic capture;      // latch the accepted core request
    logic execLatch;    // latch lookup results and outgoing time
    logic storeLocal;   // write store data into the usable line
    logic installFill;  // install returned line
    logic mergeStall;   // fold acknowledgement time into thread stall time
  } ctrlStrobes_t;

endpackage

// File: rtl/lease_l1_dpath.sv
module lease_l1_dpath
  import lease_l1_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int TIME_W  = 16,
  parameter int LINES   = 8,
  parameter int THREADS = 4,
  parameter int THR_W   = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [1:0]        reqOp,
  input  logic [THR_W-1:0]  reqThread,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [DATA_W-1:0] reqWdata,
  input  logic [TIME_W-1:0] globalTime,
  input  logic [TIME_W-1:0] leaseLen,
  input  logic [DATA_W-1:0] l2RespData,
  input  logic [TIME_W-1:0] l2RespGwct,
  output logic              lineHit,
  output logic              fenceDone,
  output logic [1:0]        opQ,
  output logic [ADDR_W-1:0] addrQ,
  output logic [DATA_W-1:0] wdataQ,
  output logic [TIME_W-1:0] reqTimeQ,
  output logic [DATA_W-1:0] respDataQ
);

  localparam int IDX_W = $clog2(LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [THR_W-1:0]  thrQ;
  logic [LINES-1:0]  validArr;
  logic [TAG_W-1:0]  tagArr   [LINES];
  logic [DATA_W-1:0] dataArr  [LINES];
  logic [TIME_W-1:0] leaseArr [LINES];
  logic [TIME_W-1:0] stallArr [THREADS];

  logic [IDX_W-1:0] idx;
  logic [TAG_W-1:0] tagQ;

  assign idx  = addrQ[IDX_W-1:0];
  assign tagQ = addrQ[ADDR_W-1:IDX_W];

  // A line is usable only while its stamp has not fallen behind global time
  assign lineHit   = validArr[idx] && (tagArr[idx] == tagQ) && (leaseArr[idx] >= globalTime);
  assign fenceDone = globalTime >= stallArr[thrQ];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      thrQ      <= '0;
      opQ       <= '0;
      addrQ     <= '0;
      wdataQ    <= '0;
      validArr  <= '0;
      reqTimeQ  <= '0;
      respDataQ <= '0;
    end else begin
      if (strb.capture) begin
        thrQ   <= reqThread;
        opQ    <= reqOp;
        addrQ  <= reqAddr;
        wdataQ <= reqWdata;
      end
      if (strb.execLatch) begin
        respDataQ <= dataArr[idx];
        if (opQ == OP_LOAD)   reqTimeQ <= globalTime + leaseLen;
        else if (lineHit)     reqTimeQ <= leaseArr[idx];
        else                  reqTimeQ <= '0;
      end
      if (strb.installFill) begin
        validArr[idx] <= 1'b1;
        respDataQ     <= l2RespData;
      end
    end
  end

  // Line payload needs no reset: the valid bits guard it
  always_ff @(posedge clk) begin
    if (strb.installFill) begin
      tagArr[idx]   <= tagQ;
      dataArr[idx]  <= l2RespData;
      leaseArr[idx] <= reqTimeQ;
    end else if (strb.storeLocal) begin
      dataArr[idx]  <= wdataQ;
    end
  end

  // One stall-time register per thread, keeping the largest completion time
  for (genvar t = 0; t < THREADS; t++) begin : g_stall
    logic [TIME_W-1:0] stallQ;
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stallQ <= '0;
      else if (strb.mergeStall && (thrQ == THR_W'(t)) && (l2RespGwct > stallQ))
        stallQ <= l2RespGwct;
    end
    assign stallArr[t] = stallQ;
  end

endmodule

// File: rtl/lease_l1_fsm.sv
module lease_l1_fsm
  import lease_l1_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         coreReqValid,
  input  logic         l2ReqReady,
  input  logic         l2RespValid,
  input  logic         l2RespKind,
  input  logic [1:0]   opQ,
  input  logic         lineHit,
  input  logic         fenceDone,
  output logic         coreReqReady,
  output logic         coreRespValid,
  output logic         l2ReqValid,
  output logic [1:0]   l2ReqKind,
  output ctrlStrobes_t strb
);

  typedef enum logic [2:0] {
    S_IDLE, S_EXEC, S_MISS_REQ, S_MISS_WAIT, S_WR_REQ, S_WR_WAIT, S_FENCE, S_RESP
  } state_e;

  state_e  state, nextState;
  l2Kind_e kindQ;

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      S_IDLE: if (coreReqValid) begin
        strb.capture = 1'b1;
        nextState    = S_EXEC;
      end
      S_EXEC: begin
        strb.execLatch = 1'b1;
        if (opQ == OP_LOAD) begin
          nextState = lineHit ? S_RESP : S_MISS_REQ;
        end else if (opQ == OP_STORE) begin
          strb.storeLocal = lineHit;
          nextState       = S_WR_REQ;
        end else begin
          nextState = S_FENCE;
        end
      end
      S_MISS_REQ:  if (l2ReqReady) nextState = S_MISS_WAIT;
      S_MISS_WAIT: if (l2RespValid && l2RespKind == RESP_FILL) begin
        strb.installFill = 1'b1;
        nextState        = S_RESP;
      end
      S_WR_REQ:    if (l2ReqReady) nextState = S_WR_WAIT;
      S_WR_WAIT:   if (l2RespValid && l2RespKind == RESP_ACK) begin
        strb.mergeStall = 1'b1;
        nextState       = S_RESP;
      end
      S_FENCE:     if (fenceDone) nextState = S_RESP;
      default:     nextState = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state <= S_IDLE;
      kindQ <= L2_GETV;
    end else begin
      state <= nextState;
      if (state == S_EXEC) begin
        if (opQ == OP_LOAD) kindQ <= L2_GETV;
        else if (lineHit)   kindQ <= L2_WRITEV;
        else                kindQ <= L2_WRITE;
      end
    end
  end

  assign coreReqReady  = (state == S_IDLE);
  assign coreRespValid = (state == S_RESP);
  assign l2ReqValid    = (state == S_MISS_REQ) || (state == S_WR_REQ);
  assign l2ReqKind     = kindQ;

endmodule

// File: rtl/lease_l1.sv
module lease_l1
  import lease_l1_pkg::*;
#(
  parameter int ADDR_W  = 16,
  parameter int DATA_W  = 32,
  parameter int TIME_W  = 16,
  parameter int LINES   = 8,
  parameter int THREADS = 4,
  localparam int THR_W  = (THREADS > 1) ? $clog2(THREADS) : 1
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [TIME_W-1:0] globalTime,
  input  logic [TIME_W-1:0] leaseLen,
  input  logic              coreReqValid,
  output logic              coreReqReady,
  input  logic [1:0]        coreReqOp,
  input  logic [THR_W-1:0]  coreReqThread,
  input  logic [ADDR_W-1:0] coreReqAddr,
  input  logic [DATA_W-1:0] coreReqWdata,
  output logic              coreRespValid,
  output logic [DATA_W-1:0] coreRespData,
  output logic              l2ReqValid,
  input  logic              l2ReqReady,
  output logic [1:0]        l2ReqKind,
  output logic [ADDR_W-1:0] l2ReqAddr,
  output logic [DATA_W-1:0] l2ReqData,
  output logic [TIME_W-1:0] l2ReqTime,
  input  logic              l2RespValid,
  input  logic              l2RespKind,
  input  logic [DATA_W-1:0] l2RespData,
  input  logic [TIME_W-1:0] l2RespGwct
);

  ctrlStrobes_t strb;
  logic         lineHit;
  logic         fenceDone;
  logic [1:0]   opQ;

  lease_l1_fsm u_fsm (
    .clk          (clk),
    .rstN         (rstN),
    .coreReqValid (coreReqValid),
    .l2ReqReady   (l2ReqReady),
    .l2RespValid  (l2RespValid),
    .l2RespKind   (l2RespKind),
    .opQ          (opQ),
    .lineHit      (lineHit),
    .fenceDone    (fenceDone),
    .coreReqReady (coreReqReady),
    .coreRespValid(coreRespValid),
    .l2ReqValid   (l2ReqValid),
    .l2ReqKind    (l2ReqKind),
    .strb         (strb)
  );

  lease_l1_dpath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W),
    .TIME_W (TIME_W),
    .LINES  (LINES),
    .THREADS(THREADS),
    .THR_W  (THR_W)
  ) u_dpath (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqOp     (coreReqOp),
    .reqThread (coreReqThread),
    .reqAddr   (coreReqAddr),
    .reqWdata  (coreReqWdata),
    .globalTime(globalTime),
    .leaseLen  (leaseLen),
    .l2RespData(l2RespData),
    .l2RespGwct(l2RespGwct),
    .lineHit   (lineHit),
    .fenceDone (fenceDone),
    .opQ       (opQ),
    .addrQ     (l2ReqAddr),
    .wdataQ    (l2ReqData),
    .reqTimeQ  (l2ReqTime),
    .respDataQ (coreRespData)
  );

endmodule

// File: rtl/lease_l1_checker.sv
module lease_l1_checker #(
  parameter int ADDR_W = 16,
  parameter int TIME_W = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic              coreReqValid,
  input logic              coreReqReady,
  input logic              coreRespValid,
  input logic              l2ReqValid,
  input logic              l2ReqReady,
  input logic [1:0]        l2ReqKind,
  input logic [ADDR_W-1:0] l2ReqAddr,
  input logic [TIME_W-1:0] l2ReqTime
);

  // R1: reset leaves the controller idle
  p_reset_idle_r1: assert property (@(posedge clk)
    !rstN |=> (coreReqReady && !coreRespValid && !l2ReqValid));

  // R9: no new acceptance while an L2 request or a response is presented
  p_busy_r9: assert property (@(posedge clk) disable iff (!rstN)
    (l2ReqValid || coreRespValid) |-> !coreReqReady);

  // R9: an accepted request closes the door
  p_accept_r9: assert property (@(posedge clk) disable iff (!rstN)
    (coreReqValid && coreReqReady) |=> !coreReqReady);

  // R2: the response is a single-cycle pulse followed by readiness
  p_resp_pulse_r2: assert property (@(posedge clk) disable iff (!rstN)
    coreRespValid |=> (!coreRespValid && coreReqReady));

  // R6: a plain write carries no lease
  p_write_nolease_r6: assert property (@(posedge clk) disable iff (!rstN)
    (l2ReqValid && l2ReqKind == 2'd1) |-> (l2ReqTime == '0));

  // R3: a stalled L2 request holds its contents
  p_hold_req_r3: assert property (@(posedge clk) disable iff (!rstN)
    (l2ReqValid && !l2ReqReady) |=>
      (l2ReqValid && $stable(l2ReqAddr) && $stable(l2ReqKind) && $stable(l2ReqTime)));

endmodule

bind lease_l1 lease_l1_checker #(
  .ADDR_W(ADDR_W),
  .TIME_W(TIME_W)
) u_chk (
  .clk          (clk),
  .rstN         (rstN),
  .coreReqValid (coreReqValid),
  .coreReqReady (coreReqReady),
  .coreRespValid(coreRespValid),
  .l2ReqValid   (l2ReqValid),
  .l2ReqReady   (l2ReqReady),
  .l2ReqKind    (l2ReqKind),
  .l2ReqAddr    (l2ReqAddr),
  .l2ReqTime    (l2ReqTime)
);

// File: tb/tb_lease_l1.sv
`timescale 1ns/1ps
module tb_lease_l1;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [15:0] globalTime = '0;
  logic [15:0] leaseLen = 16'd20;
  logic        coreReqValid = 1'b0;
  logic        coreReqReady;
  logic [1:0]  coreReqOp = '0;
  logic [1:0]  coreReqThread = '0;
  logic [15:0] coreReqAddr = '0;
  logic [31:0] coreReqWdata = '0;
  logic        coreRespValid;
  logic [31:0] coreRespData;
  logic        l2ReqValid;
  logic        l2ReqReady = 1'b1;
  logic [1:0]  l2ReqKind;
  logic [15:0] l2ReqAddr;
  logic [31:0] l2ReqData;
  logic [15:0] l2ReqTime;
  logic        l2RespValid = 1'b0;
  logic        l2RespKind = 1'b0;
  logic [31:0] l2RespData = '0;
  logic [15:0] l2RespGwct = '0;

  always #2 clk = ~clk;

  lease_l1 dut (.*);

  int nChecks = 0;
  int nFail = 0;
  bit done = 0;

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // ---------------- L2 responder ----------------
  logic [31:0] l2Mem [256];
  int   stallReady = 0;
  int   respLat = 1;
  logic [15:0] gwctNext = '0;
  int   getvCount = 0;
  logic [1:0]  lastKind;
  logic [15:0] lastTime;
  bit   pend = 0;
  int   pendCnt = 0;
  logic pendKind;
  logic [31:0] pendData;
  int   timeStep = 0;

  initial for (int i = 0; i < 256; i++) l2Mem[i] = 32'hA000_0000 + i;

  always @(negedge clk) begin
    globalTime <= globalTime + 16'(timeStep);
    l2RespValid = 1'b0;
    if (pend) begin
      if (pendCnt == 0) begin
        l2RespValid = 1'b1;
        l2RespKind  = pendKind;
        l2RespData  = pendData;
        l2RespGwct  = gwctNext;
        pend = 0;
      end else pendCnt--;
    end
    if (stallReady > 0) begin
      l2ReqReady = 1'b0;
      stallReady--;
    end else l2ReqReady = 1'b1;
    if (rstN && l2ReqValid && l2ReqReady) begin
      lastKind = l2ReqKind;
      lastTime = l2ReqTime;
      pend     = 1;
      pendCnt  = respLat;
      if (l2ReqKind == 2'd0) begin
        getvCount++;
        pendKind = 1'b0;
        pendData = l2Mem[l2ReqAddr[7:0]];
      end else begin
        pendKind = 1'b1;
        l2Mem[l2ReqAddr[7:0]] = l2ReqData;
        pendData = '0;
      end
    end
  end

  // ---------------- behavioural reference model ----------------
  int          mPhase;
  bit          mValid [8];
  logic [12:0] mTag [8];
  logic [31:0] mData [8];
  logic [15:0] mLease [8];
  logic [15:0] mStall [4];
  int          mThr;
  logic [15:0] mAddr;
  logic [31:0] mWdata;
  logic [1:0]  mOp;
  logic [31:0] mResp;
  logic [15:0] mTime;
  logic [1:0]  mKind;

  always @(posedge clk) begin
    if (!rstN) begin
      mPhase = 0;
      for (int i = 0; i < 8; i++) mValid[i] = 0;
      for (int i = 0; i < 4; i++) mStall[i] = '0;
    end else begin
      int  ix;
      bit  hit;
      ix  = int'(mAddr[2:0]);
      hit = mValid[ix] && (mTag[ix] == mAddr[15:3]) && (mLease[ix] >= globalTime);
      case (mPhase)
        0: if (coreReqValid) begin
          mThr = int'(coreReqThread); mAddr = coreReqAddr; mWdata = coreReqWdata; mOp = coreReqOp;
          mPhase = 1;
        end
        1: begin
          if (mOp == 2'd0) begin
            if (hit) begin mResp = mData[ix]; mPhase = 7; end
            else begin mKind = 2'd0; mTime = globalTime + leaseLen; mPhase = 2; end
          end else if (mOp == 2'd1) begin
            if (hit) begin mData[ix] = mWdata; mKind = 2'd2; mTime = mLease[ix]; end
            else begin mKind = 2'd1; mTime = '0; end
            mPhase = 4;
          end else mPhase = 6;
        end
        2: if (l2ReqReady) mPhase = 3;
        3: if (l2RespValid && !l2RespKind) begin
          mValid[ix] = 1; mTag[ix] = mAddr[15:3]; mData[ix] = l2RespData; mLease[ix] = mTime;
          mResp = l2RespData; mPhase = 7;
        end
        4: if (l2ReqReady) mPhase = 5;
        5: if (l2RespValid && l2RespKind) begin
          if (l2RespGwct > mStall[mThr]) mStall[mThr] = l2RespGwct;
          mPhase = 7;
        end
        6: if (globalTime >= mStall[mThr]) mPhase = 7;
        default: mPhase = 0;
      endcase
    end
  end

  // per-clock comparison, away from the active edge
  always @(negedge clk) begin
    if (rstN) begin
      chk("R9", "coreReqReady", 32'(coreReqReady), 32'(mPhase == 0));
      chk("R2", "coreRespValid", 32'(coreRespValid), 32'(mPhase == 7));
      if (mPhase == 7 && mOp == 2'd0) chk("R4", "coreRespData", coreRespData, mResp);
      chk("R3", "l2ReqValid", 32'(l2ReqValid), 32'(mPhase == 2 || mPhase == 4));
      if (mPhase == 2 || mPhase == 4) begin
        chk("R5", "l2ReqKind", 32'(l2ReqKind), 32'(mKind));
        chk("R10", "l2ReqAddr", 32'(l2ReqAddr), 32'(mAddr));
        chk("R6", "l2ReqTime", 32'(l2ReqTime), 32'(mTime));
        if (mPhase == 4) chk("R5", "l2ReqData", l2ReqData, mWdata);
      end
    end
  end

  // ---------------- stimulus ----------------
  task automatic doOp(input logic [1:0] op, input logic [1:0] thr, input logic [15:0] addr,
                      input logic [31:0] wd, output logic [31:0] rd, output logic [15:0] tDone);
    @(negedge clk);
    coreReqValid = 1'b1; coreReqOp = op; coreReqThread = thr;
    coreReqAddr = addr; coreReqWdata = wd;
    while (!coreReqReady) @(negedge clk);
    @(negedge clk);
    coreReqValid = 1'b0;
    while (!coreRespValid) @(negedge clk);
    rd = coreRespData;
    tDone = globalTime;
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFail);
  endtask

  initial begin
    logic [31:0] rd;
    logic [15:0] td;
    int g0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    globalTime = 16'd5;
    // R1: idle after reset
    chk("R1", "ready after reset", 32'(coreReqReady), 32'd1);
    chk("R1", "no resp after reset", 32'(coreRespValid), 32'd0);
    chk("R1", "no l2 req after reset", 32'(l2ReqValid), 32'd0);

    // R3/R4: first load misses and fills
    g0 = getvCount;
    doOp(2'd0, 2'd0, 16'h0012, '0, rd, td);
    chk("R3", "first load fetches", 32'(getvCount - g0), 32'd1);
    chk("R4", "fill data", rd, 32'hA000_0012);
    chk("R3", "fetch stamp", 32'(lastTime), 32'd25);

    // R2: hit makes no L2 traffic
    g0 = getvCount;
    doOp(2'd0, 2'd0, 16'h0012, '0, rd, td);
    chk("R2", "hit no fetch", 32'(getvCount - g0), 32'd0);
    chk("R2", "hit data", rd, 32'hA000_0012);

    // R5/R7: store to usable line, two acks with shrinking times
    gwctNext = 16'd40;
    doOp(2'd1, 2'd0, 16'h0012, 32'h1111_2222, rd, td);
    chk("R5", "store kind lease write", 32'(lastKind), 32'd2);
    chk("R5", "store carries stamp", 32'(lastTime), 32'd25);
    gwctNext = 16'd20;
    stallReady = 3;
    doOp(2'd1, 2'd0, 16'h0012, 32'h3333_4444, rd, td);
    chk("R7", "second store kind", 32'(lastKind), 32'd2);
    g0 = getvCount;
    doOp(2'd0, 2'd0, 16'h0012, '0, rd, td);
    chk("R5", "local copy updated", rd, 32'h3333_4444);
    chk("R5", "no fetch after store", 32'(getvCount - g0), 32'd0);

    // R6: store to absent line, no allocate
    gwctNext = 16'd0;
    doOp(2'd1, 2'd1, 16'h0035, 32'h5555_6666, rd, td);
    chk("R6", "plain write kind", 32'(lastKind), 32'd1);
    chk("R6", "plain write time", 32'(lastTime), 32'd0);
    g0 = getvCount;
    respLat = 3;
    doOp(2'd0, 2'd1, 16'h0035, '0, rd, td);
    chk("R6", "no allocate, load misses", 32'(getvCount - g0), 32'd1);
    chk("R6", "load sees written data", rd, 32'h5555_6666);

    // R8: other thread fence returns at once
    doOp(2'd2, 2'd1, '0, '0, rd, td);
    chk("R8", "thread 1 fence immediate", 32'(td < 16'd8), 32'd1);

    // R7/R8: thread 0 fence waits for the max completion time 40
    timeStep = 1;
    doOp(2'd3, 2'd0, '0, '0, rd, td);
    chk("R7", "fence not before max time", 32'(td >= 16'd40), 32'd1);
    chk("R8", "fence not late", 32'(td <= 16'd44), 32'd1);

    // R3: stamp 25 has passed, line self-invalidates
    g0 = getvCount;
    doOp(2'd0, 2'd0, 16'h0012, '0, rd, td);
    chk("R3", "expired line refetched", 32'(getvCount - g0), 32'd1);
    chk("R4", "refetch data", rd, 32'h3333_4444);

    // R10: index conflict evicts
    timeStep = 0;
    respLat = 0;
    doOp(2'd0, 2'd2, 16'h001A, '0, rd, td);
    chk("R10", "conflict fill data", rd, 32'hA000_001A);
    g0 = getvCount;
    doOp(2'd0, 2'd2, 16'h0012, '0, rd, td);
    chk("R10", "evicted line misses", 32'(getvCount - g0), 32'd1);
    g0 = getvCount;
    doOp(2'd0, 2'd3, 16'h0012, '0, rd, td);
    chk("R2", "reinstalled line hits", 32'(getvCount - g0), 32'd0);

    repeat (4) @(negedge clk);
    done = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nChecks++;
      nFail++;
      $display("FAIL watchdog: run did not complete actual=hung expected=done");
      summary();
      $finish;
    end
  end

endmodule